// File: doc/BRIEF.md
# Filtered External Interrupt Controller

This block takes five asynchronous interrupt pins, brings each one into the core clock domain through a two-stage synchronizer, and passes it through a digital glitch filter. The filter holds back level changes until the input has stayed at the new level for a set number of samples. A change in the filtered level on the selected edge sets a sticky per-source request flag. Software clears a flag by writing a 1 to its bit at the acknowledge address.

A mode input selects the filter time base. In fast mode the filter samples on every core clock. In slow mode it samples only on a one-cycle sub-clock tick supplied from outside. Sources 0 and 4 react only to falling edges. Sources 1 to 3 each have an edge polarity bit. Source 1 has a choice of a short or a long filter. Source 0 also has a gate bit that must be set before it can raise a request.

Top module: `extint_filter_ctrl`

## Requirements
- R1: While `rst` is high, and after it is released, `irq_o` is 0. Configuration resets to 0: source 0 is gated off, sources 1 to 3 trigger on falling edges, and source 1 uses the short filter.
- R2: Each pin goes through two synchronizer flops. The filtered level loads from the synchronized pin during reset, so a pin held low through reset release raises no request.
- R3: In fast mode, sources 0 and 4 ignore low pulses of 1 clock and latch pulses of 7 clocks or more.
- R4: In fast mode with config bit 1 = 0 (short filter), source 1 ignores pulses of 14 clocks and latches pulses of 49 clocks or more. With bit 1 = 1 (long filter), it ignores 62-clock pulses and latches pulses of 193 clocks or more.
- R5: In fast mode, sources 2 and 3 ignore pulses of 6 clocks and latch pulses of 25 clocks or more.
- R6: With `slow_mode_i` = 1, every source samples only on `sub_tick_i`. A pulse shorter than one tick period is ignored, and a pulse of 3.5 tick periods or more is latched.
- R7: In slow mode, a clean pin edge sets its flag within 2 clocks plus 6 tick periods.
- R8: Config bits 2, 3 and 4 select the rising edge (1) or the falling edge (0) for sources 1, 2 and 3. Sources 0 and 4 never latch on a rising edge.
- R9: Source 0 latches only while config bit 0 = 1. An accepted falling edge seen while the bit is 0 leaves `irq_o[0]` at 0.
- R10: A write with `wr_addr_i` = 0 loads the 5-bit config. A write with `wr_addr_i` = 1 clears each flag whose data bit is 1, effective at the next clock edge.
- R11: If a set and a clear of the same flag fall on the same clock edge, the flag ends up set.
- R12: A set flag stays set until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_mode_i | input | 1 | 1 = filter samples on sub-clock ticks |
| sub_tick_i | input | 1 | One-cycle pulse per sub-clock period |
| pin_i | input | 5 | Asynchronous interrupt pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = config, 1 = acknowledge |
| wr_data_i | input | 5 | Write data |
| irq_o | output | 5 | Latched interrupt requests |

## Verification
The hardest case to reach from the ports is a clear that lands on exactly the same edge as a set. The bench cannot see inside the pipeline, so it does not try to aim for that edge. Instead it sweeps the acknowledge write across fifteen consecutive cycle offsets after a pin falls. For each offset it records whether the flag was already visible before the write. It then expects the flag to end up cleared only in those runs, so the one offset where the two events collide must leave the flag set.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int NUM_SRC   = 5;
  localparam int CFG_W     = 5;
  // config register bit positions
  localparam int CFG_EN0   = 0;
  localparam int CFG_LONG1 = 1;
  localparam int CFG_RISE1 = 2; // sources 1..3 use bits 2..4
  localparam logic ADDR_CFG = 1'b0;
  localparam logic ADDR_ACK = 1'b1;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= d_i;
    for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/extint_glitch_filter.sv
module extint_glitch_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             rose_o,
  output logic             fell_o
);
  logic             filt_q, prev_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= din_i;
      prev_q <= din_i;
      cnt_q  <= '0;
    end else begin
      prev_q <= filt_q;
      if (tick_i) begin
        if (din_i == filt_q) begin
          cnt_q <= '0;
        end else if (cnt_q >= lim_i) begin
          filt_q <= din_i;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rose_o = filt_q & ~prev_q;
  assign fell_o = ~filt_q & prev_q;

  // R6
  filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(filt_q));

  // R3
  agree_clears_chk: assert property (@(posedge clk) disable iff (rst)
    tick_i && (din_i == filt_q) |=> cnt_q == '0);
endmodule

// File: rtl/extint_latch_bank.sv
module extint_latch_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst) q_o <= '0;
    else     q_o <= (q_o & ~clr_i) | set_i;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> q_o == '0);

  for (genvar i = 0; i < W; i++) begin : g_chk
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> q_o[i]);
    // R10
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] && !set_i[i] |=> !q_o[i]);
    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      q_o[i] && !clr_i[i] |=> q_o[i]);
  end
endmodule

// File: rtl/extint_filter_ctrl.sv
module extint_filter_ctrl
  import extint_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int N_EDGE  = 4,
  parameter int N_MID   = 16,
  parameter int N_SHORT = 32,
  parameter int N_LONG  = 128,
  parameter int N_SLOW  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               slow_mode_i,
  input  logic               sub_tick_i,
  input  logic [NUM_SRC-1:0] pin_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  output logic [NUM_SRC-1:0] irq_o
);
  localparam logic [CNT_W-1:0] LIM_EDGE  = CNT_W'(N_EDGE - 1);
  localparam logic [CNT_W-1:0] LIM_MID   = CNT_W'(N_MID - 1);
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(N_SHORT - 1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(N_LONG - 1);
  localparam logic [CNT_W-1:0] LIM_SLOW  = CNT_W'(N_SLOW - 1);

  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_SRC-1:0] pin_s, rose, fell, evt, ack;
  logic               tick;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_CFG) cfg_q <= wr_data_i;
  end

  assign ack  = (wr_en_i && wr_addr_i == ADDR_ACK) ? wr_data_i : '0;
  assign tick = slow_mode_i ? sub_tick_i : 1'b1;

  extint_sync #(.WIDTH(NUM_SRC), .STAGES(2)) sync_i (
    .clk(clk), .d_i(pin_i), .q_o(pin_s));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [CNT_W-1:0] lim_fast, lim;
    logic             rise_sel;

    if (i == 0 || i == NUM_SRC-1) begin : g_edge_only
      assign lim_fast = LIM_EDGE;
      assign rise_sel = 1'b0;
    end else if (i == 1) begin : g_selectable_len
      assign lim_fast = cfg_q[CFG_LONG1] ? LIM_LONG : LIM_SHORT;
      assign rise_sel = cfg_q[CFG_RISE1];
    end else begin : g_mid
      assign lim_fast = LIM_MID;
      assign rise_sel = cfg_q[CFG_RISE1 + i - 1];
    end

    assign lim = slow_mode_i ? LIM_SLOW : lim_fast;

    extint_glitch_filter #(.CNT_W(CNT_W)) filt_i (
      .clk(clk), .rst(rst), .din_i(pin_s[i]), .tick_i(tick),
      .lim_i(lim), .rose_o(rose[i]), .fell_o(fell[i]));

    if (i == 0) begin : g_gated
      assign evt[i] = fell[i] & cfg_q[CFG_EN0];
    end else begin : g_free
      assign evt[i] = rise_sel ? rose[i] : fell[i];
    end
  end

  extint_latch_bank #(.W(NUM_SRC)) latch_i (
    .clk(clk), .rst(rst), .set_i(evt), .clr_i(ack), .q_o(irq_o));

  // R9
  src0_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[CFG_EN0] && !irq_o[0] |=> !irq_o[0]);

  // R8
  src4_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rose[NUM_SRC-1] && !irq_o[NUM_SRC-1] |=> !irq_o[NUM_SRC-1]);
endmodule

// File: tb/extint_filter_ctrl_tb_top.sv
`timescale 1ns/1ps
module extint_filter_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       slow = 1'b0, tick = 1'b0;
  logic [4:0] pin = 5'h1f;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] irq;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  extint_filter_ctrl dut_i (
    .clk(clk), .rst(rst), .slow_mode_i(slow), .sub_tick_i(tick),
    .pin_i(pin), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .irq_o(irq));

  typedef struct packed {
    logic [2:0] src;
    logic [7:0] w;
    logic       slw;
    logic       lng;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{3'd0, 8'd1,   1'b0, 1'b0, 1'b0},  // R3
    '{3'd0, 8'd7,   1'b0, 1'b0, 1'b1},  // R3
    '{3'd4, 8'd1,   1'b0, 1'b0, 1'b0},  // R3
    '{3'd4, 8'd7,   1'b0, 1'b0, 1'b1},  // R3
    '{3'd1, 8'd14,  1'b0, 1'b0, 1'b0},  // R4
    '{3'd1, 8'd49,  1'b0, 1'b0, 1'b1},  // R4
    '{3'd1, 8'd62,  1'b0, 1'b0, 1'b1},  // R4
    '{3'd1, 8'd62,  1'b0, 1'b1, 1'b0},  // R4
    '{3'd1, 8'd193, 1'b0, 1'b1, 1'b1},  // R4
    '{3'd2, 8'd6,   1'b0, 1'b0, 1'b0},  // R5
    '{3'd2, 8'd25,  1'b0, 1'b0, 1'b1},  // R5
    '{3'd3, 8'd6,   1'b0, 1'b0, 1'b0},  // R5
    '{3'd3, 8'd25,  1'b0, 1'b0, 1'b1},  // R5
    '{3'd0, 8'd4,   1'b1, 1'b0, 1'b0},  // R6
    '{3'd2, 8'd28,  1'b1, 1'b0, 1'b1},  // R6
    '{3'd1, 8'd28,  1'b1, 1'b1, 1'b1}   // R6
  };

  // sub-clock tick every 8 core clocks
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c  = (c + 1) % 8;
      tick = (c == 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic a, input logic [4:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    cyc(6);
    check("R1", irq, 5'h00);
    rst = 1'b0;
    cyc(3);
    check("R1", irq, 5'h00);

    // table-driven filter thresholds
    foreach (VEC[k]) begin
      slow = VEC[k].slw;
      wr(1'b0, {3'b000, VEC[k].lng, 1'b1});
      cyc(20);
      pin[VEC[k].src] = 1'b0;
      cyc(int'(VEC[k].w));
      pin[VEC[k].src] = 1'b1;
      cyc(400);
      check(VEC[k].slw ? "R6" : (VEC[k].src == 1 ? "R4" :
            (VEC[k].src == 0 || VEC[k].src == 4) ? "R3" : "R5"),
            irq, 5'(VEC[k].exp) << VEC[k].src);
      wr(1'b1, 5'h1f);
      cyc(2);
    end
    slow = 1'b0;

    // R12 flag holds, R10 acknowledge of a different bit has no effect
    pin[4] = 1'b0; cyc(30); pin[4] = 1'b1; cyc(200);
    check("R12", irq, 5'h10);
    wr(1'b1, 5'h0f); cyc(2);
    check("R10", irq, 5'h10);
    wr(1'b1, 5'h10); cyc(1);
    check("R10", irq, 5'h00);

    // R9 source 0 gated off
    wr(1'b0, 5'h00);
    pin[0] = 1'b0; cyc(30); pin[0] = 1'b1; cyc(50);
    check("R9", irq, 5'h00);

    // R8 polarity: source 2 rising, source 4 falling only
    wr(1'b0, 5'b01000);
    pin[2] = 1'b0; pin[4] = 1'b0; cyc(100);
    check("R8", irq, 5'h10);
    wr(1'b1, 5'h1f); cyc(2);
    pin[2] = 1'b1; pin[4] = 1'b1; cyc(100);
    check("R8", irq, 5'h04);
    wr(1'b1, 5'h1f); cyc(2);
    wr(1'b0, 5'h00);

    // R7 slow-mode latency
    slow = 1'b1; cyc(20);
    pin[4] = 1'b0;
    cyc(2 + 48);
    check("R7", irq, 5'h10);
    pin[4] = 1'b1; cyc(60);
    wr(1'b1, 5'h1f); cyc(2);
    slow = 1'b0;

    // R11 sweep acknowledge across the set cycle
    for (int off = 0; off < 15; off++) begin
      logic pre;
      pin[4] = 1'b0;
      cyc(off);
      pre = irq[4];
      wr(1'b1, 5'h10);
      cyc(20);
      check("R11", irq, {~pre, 4'h0});
      pin[4] = 1'b1; cyc(20);
      wr(1'b1, 5'h1f); cyc(2);
    end

    // R2 pins low through reset: no spurious request
    pin = 5'h00;
    rst = 1'b1; cyc(5);
    check("R1", irq, 5'h00);
    rst = 1'b0;
    wr(1'b0, 5'h01);
    cyc(100);
    check("R2", irq, 5'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule